// File: doc/BRIEF.md
# PSRAM Power-Mode Sequencer

This block owns the power-mode enable pin (chip enable 2) of a pseudo-static RAM and decides when the access controller may touch the memory. After reset it keeps the memory deselected through the power-on hold and the recovery hold. Only then does it open the gate to the access controller. While the gate is closed, the block forces the access chip enable (chip enable 1) high.

A host requests deep power-down with a level request. The request is taken only while the access controller reports idle. The block first spends one cycle with chip enable 1 forced high, then drives chip enable 2 low for at least the minimum deep power-down pulse. A wake request raises chip enable 2 again, and the block waits out the recovery hold before it reports ready. A wake request that arrives during the minimum pulse is remembered and acted on when the pulse ends.

The memory does not keep its contents through deep power-down. Every exit therefore sets a sticky flag, and the host clears it with an acknowledge. All durations are parameters in clock cycles, and the counters are sized from them.

Top module: `psram_pwr_seq`

## Requirements
- R1: While reset is high and on the first cycle after it, `ce2_o` is 1, `ce1_block_o` is 1, `ready_o` is 0 and `data_lost_o` is 0.
- R2: After reset is released, `ready_o` first reads 1 exactly PON_CYC + RECOV_CYC clock cycles later, and `ce2_o` stays 1 during that whole time.
- R3: `ready_o` is 1 only while the gate is open; whenever `ready_o` is 1, `ce1_block_o` is 0 and `ce2_o` is 1, and whenever `ready_o` is 0, `ce1_block_o` is 1.
- R4: In the ready state, `dpd_req_i` has no effect while `ctrl_idle_i` is 0; the block stays ready until the request is seen together with idle.
- R5: An accepted power-down request first gives exactly one cycle with `ready_o` 0, `ce1_block_o` 1 and `ce2_o` still 1; `ce2_o` falls only after that cycle, and `ce2_o` is never 0 while `ce1_block_o` is 0.
- R6: Once `ce2_o` falls, it stays 0 for at least DPD_MIN_CYC cycles; a wake request seen during that minimum is deferred, and `ce2_o` returns to 1 exactly DPD_MIN_CYC cycles after it fell.
- R7: With no wake request pending when the minimum ends, `ce2_o` stays 0 indefinitely; a wake request then raises `ce2_o` on the next cycle.
- R8: After `ce2_o` rises on a wake, `ready_o` becomes 1 exactly RECOV_CYC cycles later, with `ce2_o` held at 1 throughout.
- R9: `data_lost_o` becomes 1 in the same cycle that `ce2_o` rises on a wake. It stays 1 until `lost_ack_i` is sampled high, and it then reads 0 on the next cycle.
- R10: In the ready state, `wake_req_i` and `lost_ack_i` have no effect: `ready_o` stays 1, `ce2_o` stays 1 and `data_lost_o` stays 0.
- R11: `dpd_req_i` has no effect during the power-on and recovery holds. It is not remembered, and the block stays ready after the holds end once the request has been withdrawn.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dpd_req_i | input | 1 | Level request to enter deep power-down |
| wake_req_i | input | 1 | Request to leave deep power-down |
| ctrl_idle_i | input | 1 | Access controller has no access in flight |
| lost_ack_i | input | 1 | Host acknowledge that clears the data-lost flag |
| ce2_o | output | 1 | Power-mode enable to the memory, low means deep power-down |
| ce1_block_o | output | 1 | Forces the memory access chip enable high |
| ready_o | output | 1 | Access controller may start accesses |
| data_lost_o | output | 1 | Sticky flag: memory contents invalid since the last exit |

## Verification
The main sequence is tried with several input patterns, and each pattern separates one kind of fault. A power-down request held during the power-on holds shows whether requests leak past the holds. A request held while the controller is busy shows whether the idle gating works. A wake pulse early in the minimum pulse shows whether a deferred wake is lost or acted on too early. A late wake after a long stay in power-down shows the one-cycle wake response and the exact recovery length. Wake and acknowledge pulses sent while ready show whether these inputs leak into the ready state, and a delayed acknowledge shows that the data-lost flag holds until it is cleared.

// File: rtl/psram_pwr_pkg.sv
package psram_pwr_pkg;

  typedef enum logic [2:0] {
    ST_PON_WAIT  = 3'd0,
    ST_RECOVER   = 3'd1,
    ST_READY     = 3'd2,
    ST_ENTER_DPD = 3'd3,
    ST_DPD_HOLD  = 3'd4,
    ST_DPD       = 3'd5,
    ST_EXIT_WAIT = 3'd6
  } pwr_state_t;

  // chip enable 2 is low only while the memory sits in deep power-down
  function automatic logic ce2_level(input pwr_state_t s);
    return !(s == ST_DPD_HOLD || s == ST_DPD);
  endfunction

  function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                       input int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/psram_span_timer.sv
module psram_span_timer #(
  parameter int unsigned CNT_W   = 8,
  parameter int unsigned RST_VAL = 0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             zero
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= CNT_W'(RST_VAL);
    end else if (load) begin
      cnt_q <= load_val;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign zero = (cnt_q == '0);

endmodule

// File: rtl/psram_wake_latch.sv
module psram_wake_latch (
  input  logic clk,
  input  logic rst,
  input  logic arm,
  input  logic wake,
  input  logic clear,
  output logic pending
);

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      pending <= 1'b0;
    end else if (arm && wake) begin
      pending <= 1'b1;
    end
  end

endmodule

// File: rtl/psram_lost_flag.sv
module psram_lost_flag (
  input  logic clk,
  input  logic rst,
  input  logic set,
  input  logic ack,
  output logic flag
);

  always_ff @(posedge clk) begin
    if (rst) begin
      flag <= 1'b0;
    end else if (set) begin
      flag <= 1'b1;
    end else if (ack) begin
      flag <= 1'b0;
    end
  end

endmodule

// File: rtl/psram_pwr_seq.sv
module psram_pwr_seq
  import psram_pwr_pkg::*;
#(
  parameter int unsigned PON_CYC     = 3750,
  parameter int unsigned RECOV_CYC   = 37500,
  parameter int unsigned DPD_MIN_CYC = 1250000
) (
  input  logic clk,
  input  logic rst,
  input  logic dpd_req_i,
  input  logic wake_req_i,
  input  logic ctrl_idle_i,
  input  logic lost_ack_i,
  output logic ce2_o,
  output logic ce1_block_o,
  output logic ready_o,
  output logic data_lost_o
);

  localparam int unsigned MAX_SPAN = max3(PON_CYC, RECOV_CYC, DPD_MIN_CYC);
  localparam int unsigned CNT_W    = $clog2(MAX_SPAN + 1);
  localparam logic [CNT_W-1:0] RECOV_LD = CNT_W'(RECOV_CYC - 1);
  localparam logic [CNT_W-1:0] DPD_LD   = CNT_W'(DPD_MIN_CYC - 1);

  pwr_state_t       state_q, state_d;
  logic             span_done;
  logic             tmr_load;
  logic [CNT_W-1:0] tmr_val;
  logic             wake_pend;
  logic             leave_dpd;

  psram_span_timer #(
    .CNT_W  (CNT_W),
    .RST_VAL(PON_CYC - 1)
  ) u_timer (
    .clk     (clk),
    .rst     (rst),
    .load    (tmr_load),
    .load_val(tmr_val),
    .zero    (span_done)
  );

  psram_wake_latch u_wake (
    .clk    (clk),
    .rst    (rst),
    .arm    (state_q == ST_DPD_HOLD),
    .wake   (wake_req_i),
    .clear  (leave_dpd),
    .pending(wake_pend)
  );

  psram_lost_flag u_lost (
    .clk (clk),
    .rst (rst),
    .set (leave_dpd),
    .ack (lost_ack_i),
    .flag(data_lost_o)
  );

  always_comb begin
    state_d  = state_q;
    tmr_load = 1'b0;
    tmr_val  = RECOV_LD;
    unique case (state_q)
      ST_PON_WAIT: begin
        if (span_done) begin
          state_d  = ST_RECOVER;
          tmr_load = 1'b1;
          tmr_val  = RECOV_LD;
        end
      end
      ST_RECOVER, ST_EXIT_WAIT: begin
        if (span_done) state_d = ST_READY;
      end
      ST_READY: begin
        if (dpd_req_i && ctrl_idle_i) state_d = ST_ENTER_DPD;
      end
      ST_ENTER_DPD: begin
        state_d  = ST_DPD_HOLD;
        tmr_load = 1'b1;
        tmr_val  = DPD_LD;
      end
      ST_DPD_HOLD: begin
        if (span_done) begin
          if (wake_pend || wake_req_i) begin
            state_d  = ST_EXIT_WAIT;
            tmr_load = 1'b1;
            tmr_val  = RECOV_LD;
          end else begin
            state_d = ST_DPD;
          end
        end
      end
      ST_DPD: begin
        if (wake_req_i) begin
          state_d  = ST_EXIT_WAIT;
          tmr_load = 1'b1;
          tmr_val  = RECOV_LD;
        end
      end
      default: state_d = ST_PON_WAIT;
    endcase
  end

  assign leave_dpd = (state_d == ST_EXIT_WAIT) && (state_q != ST_EXIT_WAIT);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_PON_WAIT;
      ce2_o       <= 1'b1;
      ce1_block_o <= 1'b1;
      ready_o     <= 1'b0;
    end else begin
      state_q     <= state_d;
      ce2_o       <= ce2_level(state_d);
      ce1_block_o <= (state_d != ST_READY);
      ready_o     <= (state_d == ST_READY);
    end
  end

endmodule

// File: rtl/psram_pwr_seq_chk.sv
module psram_pwr_seq_chk #(
  parameter int unsigned RECOV_CYC   = 4,
  parameter int unsigned DPD_MIN_CYC = 4
) (
  input logic clk,
  input logic rst,
  input logic lost_ack_i,
  input logic ce2_o,
  input logic ce1_block_o,
  input logic ready_o,
  input logic data_lost_o
);

  int unsigned low_run;
  int unsigned high_run;

  always_ff @(posedge clk) begin
    if (rst) begin
      low_run  <= 0;
      high_run <= 0;
    end else begin
      low_run  <= ce2_o ? 0 : low_run + 1;
      high_run <= ce2_o ? high_run + 1 : 0;
    end
  end

  p_ready_open_r3: assert property (@(posedge clk) disable iff (rst)
    ready_o |-> (!ce1_block_o && ce2_o));

  p_low_needs_block_r5: assert property (@(posedge clk) disable iff (rst)
    !ce2_o |-> ce1_block_o);

  p_fall_setup_r5: assert property (@(posedge clk) disable iff (rst)
    $fell(ce2_o) |-> $past(ce1_block_o));

  p_min_pulse_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(ce2_o) |-> (low_run >= DPD_MIN_CYC));

  p_recovery_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(ready_o) |-> (high_run >= RECOV_CYC));

  p_lost_on_exit_r9: assert property (@(posedge clk) disable iff (rst)
    $rose(ce2_o) |-> data_lost_o);

  p_lost_sticky_r9: assert property (@(posedge clk) disable iff (rst)
    (data_lost_o && !lost_ack_i && ce2_o) |=> data_lost_o);

endmodule

bind psram_pwr_seq psram_pwr_seq_chk #(
  .RECOV_CYC  (RECOV_CYC),
  .DPD_MIN_CYC(DPD_MIN_CYC)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .lost_ack_i (lost_ack_i),
  .ce2_o      (ce2_o),
  .ce1_block_o(ce1_block_o),
  .ready_o    (ready_o),
  .data_lost_o(data_lost_o)
);

// File: tb/psram_pwr_seq_tb.sv
module psram_pwr_seq_tb;

  localparam int PON   = 5;
  localparam int RECOV = 8;
  localparam int DMIN  = 20;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic dpd_req = 1'b0, wake_req = 1'b0, ctrl_idle = 1'b0, lost_ack = 1'b0;
  logic ce2, blk, rdy, lost;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  psram_pwr_seq #(
    .PON_CYC(PON), .RECOV_CYC(RECOV), .DPD_MIN_CYC(DMIN)
  ) u_dut (
    .clk(clk), .rst(rst), .dpd_req_i(dpd_req), .wake_req_i(wake_req),
    .ctrl_idle_i(ctrl_idle), .lost_ack_i(lost_ack),
    .ce2_o(ce2), .ce1_block_o(blk), .ready_o(rdy), .data_lost_o(lost)
  );

  // behavioural reference: phase 0 power-on, 1 recovery, 2 ready,
  // 3 entry, 4 minimum low, 5 parked low, 6 wake recovery
  int m_ph = 0;
  int m_el = 0;
  bit m_pend = 0;
  bit m_lost = 0;

  always @(posedge clk) begin
    if (rst) begin
      m_ph = 0; m_el = 0; m_pend = 0; m_lost = 0;
    end else begin
      bit to_exit;
      to_exit = 0;
      m_el++;
      case (m_ph)
        0: if (m_el == PON) begin m_ph = 1; m_el = 0; end
        1: if (m_el == RECOV) begin m_ph = 2; m_el = 0; end
        2: if (dpd_req && ctrl_idle) begin m_ph = 3; m_el = 0; end
        3: begin m_ph = 4; m_el = 0; m_pend = 0; end
        4: begin
          if (wake_req) m_pend = 1;
          if (m_el == DMIN) begin
            if (m_pend) to_exit = 1; else m_ph = 5;
            m_el = 0;
          end
        end
        5: if (wake_req) to_exit = 1;
        6: if (m_el == RECOV) begin m_ph = 2; m_el = 0; end
        default: ;
      endcase
      if (to_exit) begin m_ph = 6; m_el = 0; m_pend = 0; m_lost = 1; end
      else if (lost_ack) m_lost = 0;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && !finished) begin
      chk("R3 ready", rdy, m_ph == 2);
      chk("R5 block", blk, m_ph != 2);
      chk("R6 ce2", ce2, !(m_ph == 4 || m_ph == 5));
      chk("R9 lost", lost, m_lost);
    end
  end

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      bad++;
      total++;
      $display("FAIL watchdog actual=running expected=done");
      summary();
      $finish;
    end
  end

  initial begin
    int n;
    int lows;
    bit ce2_dropped;
    repeat (3) @(negedge clk);
    chk("R1 ce2", ce2, 1);
    chk("R1 block", blk, 1);
    chk("R1 ready", rdy, 0);
    chk("R1 lost", lost, 0);

    // power-on with a stray power-down request
    dpd_req = 1'b1;
    rst = 1'b0;
    n = 0;
    ce2_dropped = 0;
    while (!rdy && n < 200) begin
      @(negedge clk);
      n++;
      if (n == 1) begin chk("R1 ce2 first", ce2, 1); chk("R1 block first", blk, 1); end
      if (!ce2) ce2_dropped = 1;
      if (n == 3) dpd_req = 1'b0;
    end
    chk("R2 ready latency", n, PON + RECOV);
    chk("R2 ce2 held", ce2_dropped, 0);
    ctrl_idle = 1'b1;
    repeat (3) @(negedge clk);
    chk("R11 still ready", rdy, 1);

    // stray wake and acknowledge while ready
    wake_req = 1'b1; lost_ack = 1'b1;
    @(negedge clk);
    wake_req = 1'b0; lost_ack = 1'b0;
    @(negedge clk);
    chk("R10 ready", rdy, 1);
    chk("R10 ce2", ce2, 1);
    chk("R10 lost", lost, 0);

    // request while busy
    ctrl_idle = 1'b0; dpd_req = 1'b1;
    repeat (6) @(negedge clk);
    chk("R4 busy keeps ready", rdy, 1);
    ctrl_idle = 1'b1;
    @(negedge clk);
    dpd_req = 1'b0;
    chk("R5 entry ready", rdy, 0);
    chk("R5 entry ce2", ce2, 1);
    chk("R5 entry block", blk, 1);
    @(negedge clk);
    chk("R5 ce2 fell", ce2, 0);
    lows = 1;
    wake_req = 1'b1;
    @(negedge clk);
    wake_req = 1'b0;
    if (!ce2) lows++;
    while (!ce2 && lows < 500) begin
      @(negedge clk);
      if (!ce2) lows++;
    end
    chk("R6 deferred wake low length", lows, DMIN);
    chk("R9 set on exit", lost, 1);
    n = 0;
    while (!rdy && n < 500) begin
      chk("R8 ce2 during recovery", ce2, 1);
      @(negedge clk);
      n++;
    end
    chk("R8 recovery length", n, RECOV);

    repeat (10) @(negedge clk);
    chk("R9 held without ack", lost, 1);
    lost_ack = 1'b1;
    @(negedge clk);
    lost_ack = 1'b0;
    chk("R9 cleared by ack", lost, 0);

    // park in power-down, then late wake
    dpd_req = 1'b1;
    repeat (2) @(negedge clk);
    dpd_req = 1'b0;
    repeat (DMIN + 30) @(negedge clk);
    chk("R7 parked ce2", ce2, 0);
    chk("R7 parked ready", rdy, 0);
    wake_req = 1'b1;
    @(negedge clk);
    wake_req = 1'b0;
    chk("R7 wake response", ce2, 1);
    chk("R9 set again", lost, 1);
    n = 0;
    while (!rdy && n < 500) begin @(negedge clk); n++; end
    chk("R8 recovery after late wake", n, RECOV);
    lost_ack = 1'b1;
    @(negedge clk);
    lost_ack = 1'b0;
    repeat (2) @(negedge clk);

    if (!finished) begin
      finished = 1'b1;
      summary();
      $finish;
    end
  end

endmodule